// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition flags of an 8-bit processor. Every clock edge it can fold the current ALU result into the flags: the sign bit, the zero indication, the half carry out of the low nibble and the byte parity are captured together under one arithmetic enable. The signed-overflow flag and the signed-compare flag each have their own enable, and the carry flag stores a value that a separate carry block has already computed. A chaining mode ANDs the new zero indication with the stored zero flag, so a result spread over two bytes reads as zero only when both bytes were zero.

The whole register can be written from the data bus, as when a saved status word is restored. It can also be presented on a separate output byte with an output-enable, as when the status word is saved or examined for a branch. The bus byte has a fixed layout, and bit 3 is a constant zero with no storage behind it.

Top module: `status_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every stored flag is 0, so a bus read returns 8'h00.
- R2: When arith_we is high, chain_zero is low and bus_load is low at an edge, the flags update as follows. Sign (bit 7) takes alu_res[7]. Zero (bit 6) takes alu_zero. Auxiliary carry (bit 4) takes alu_half_cy. Parity (bit 2) becomes 1 when alu_res has an even number of 1 bits.
- R3: When arith_we and chain_zero are both high (and bus_load is low), the zero flag becomes the old zero flag AND alu_zero.
- R4: When chain_zero is high but arith_we is low, the zero flag and the other arithmetic flags keep their stored values.
- R5: When v_we is high (and bus_load is low), the overflow flag (bit 1) takes alu_cy6 XOR alu_cy7, where these are the carries into and out of bit 7.
- R6: When k_we is high (and bus_load is low), the compare flag (bit 5) takes alu_res[7] XOR (alu_cy6 XOR alu_cy7). This is the signed less-than result of a subtraction.
- R7: When cy_we is high (and bus_load is low), the carry flag (bit 0) takes cy_next.
- R8: A flag whose enable is low keeps its value, whatever the other enables and the ALU inputs do.
- R9: When bus_load is high, every stored flag takes the matching bit of bus_in and all arithmetic, K, V and carry updates in that cycle are discarded. Bit 3 of bus_in is ignored.
- R10: bus_oe follows bus_rd in the same cycle. While bus_rd is high, bus_out holds the flags at bits 7,6,5,4,2,1,0 with bit 3 at 0. While bus_rd is low, bus_out is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_res | input | 8 | ALU result byte |
| alu_zero | input | 1 | ALU result is all zeros |
| alu_half_cy | input | 1 | Carry out of bit 3 |
| alu_cy6 | input | 1 | Carry into bit 7 |
| alu_cy7 | input | 1 | Carry out of bit 7 |
| arith_we | input | 1 | Update sign, zero, half carry, parity |
| chain_zero | input | 1 | AND the new zero flag with the stored one |
| k_we | input | 1 | Update compare flag |
| v_we | input | 1 | Update overflow flag |
| cy_we | input | 1 | Update carry flag |
| cy_next | input | 1 | Carry value from the carry logic |
| bus_load | input | 1 | Load all flags from bus_in |
| bus_in | input | 8 | Status byte to load |
| bus_rd | input | 1 | Present flags on bus_out |
| bus_out | output | 8 | Assembled status byte |
| bus_oe | output | 1 | bus_out is valid |

## Verification
Every update is registered. A change made at one edge shows on bus_out from that edge on, and the read path is combinational, so bus_out and bus_oe follow bus_rd within the same cycle. The bench drives an update cycle with bus_rd low and checks that the output is quiet one time unit after the falling edge. It then drives a read cycle with all enables low and compares bus_out with its model, again between edges. The read cycle also confirms that a cycle with no enables leaves the flags alone.

// File: rtl/status_flags_pkg.sv
// Shared types and bit layout for the status flag register.
package status_flags_pkg;

    localparam int BYTE_W = 8;
    // Bus bit positions; a branch unit decodes these, so they are fixed.
    localparam int POS_S  = 7;
    localparam int POS_Z  = 6;
    localparam int POS_K  = 5;
    localparam int POS_AC = 4;
    localparam int POS_NA = 3;
    localparam int POS_P  = 2;
    localparam int POS_V  = 1;
    localparam int POS_C  = 0;

    typedef struct packed {
        logic s;
        logic z;
        logic k;
        logic ac;
        logic p;
        logic v;
        logic c;
    } flags_t;

    // Places the stored flags at their bus positions, with the unused bit at zero.
    function automatic logic [BYTE_W-1:0] to_byte(flags_t f);
        logic [BYTE_W-1:0] b;
        b         = '0;
        b[POS_S]  = f.s;
        b[POS_Z]  = f.z;
        b[POS_K]  = f.k;
        b[POS_AC] = f.ac;
        b[POS_P]  = f.p;
        b[POS_V]  = f.v;
        b[POS_C]  = f.c;
        return b;
    endfunction

    // Pulls the stored flags out of a bus byte; the unused bit is dropped.
    function automatic flags_t from_byte(logic [BYTE_W-1:0] b);
        flags_t f;
        f.s  = b[POS_S];
        f.z  = b[POS_Z];
        f.k  = b[POS_K];
        f.ac = b[POS_AC];
        f.p  = b[POS_P];
        f.v  = b[POS_V];
        f.c  = b[POS_C];
        return f;
    endfunction

endpackage

// File: rtl/flag_calc.sv
// Computes candidate flag values from one ALU result.
// Assumes: the carries into and out of the top bit are supplied by the ALU.
module flag_calc #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] res,
    input  logic          cy_in_top,
    input  logic          cy_out_top,
    output logic          sign,
    output logic          parity_even,
    output logic          ovf,
    output logic          less
);
    localparam int MSB = DW - 1;

    // Derives sign, parity, signed overflow and signed less-than.
    always_comb begin
        sign        = res[MSB];
        parity_even = ~(^res);
        ovf         = cy_in_top ^ cy_out_top;
        less        = res[MSB] ^ ovf;
    end

endmodule

// File: rtl/flag_store.sv
// Holds the seven flags. Each group has its own enable, and a bus load overrides all of them.
// Assumes: the inputs are stable around the rising clock edge; reset is synchronous and active-low.
module flag_store
    import status_flags_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   arith_we,
    input  logic   chain_zero,
    input  logic   k_we,
    input  logic   v_we,
    input  logic   cy_we,
    input  logic   load,
    input  flags_t load_val,
    input  logic   n_sign,
    input  logic   n_zero,
    input  logic   n_ac,
    input  logic   n_par,
    input  logic   n_k,
    input  logic   n_v,
    input  logic   n_c,
    output flags_t q
);
    logic z_next;

    // Selects a plain or chained zero result.
    always_comb begin
        z_next = chain_zero ? (q.z & n_zero) : n_zero;
    end

    // Register update: reset, then bus load, then per-group enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else begin
            if (arith_we) begin
                q.s  <= n_sign;
                q.z  <= z_next;
                q.ac <= n_ac;
                q.p  <= n_par;
            end
            if (k_we) q.k <= n_k;
            if (v_we) q.v <= n_v;
            if (cy_we) q.c <= n_c;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> q == '0);
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_val));
    p_chain_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && arith_we && chain_zero) |=> q.z == ($past(q.z) & $past(n_zero)));
    p_chain_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !arith_we && chain_zero) |=> $stable(q.z));
    p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cy_we) |=> $stable(q.c));
    p_k_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !k_we) |=> $stable(q.k));

endmodule

// File: rtl/flag_bus.sv
// Presents the stored flags as a bus byte when read is requested; drives zero otherwise.
// Assumes: the consumer samples bus_out only while oe is high.
module flag_bus
    import status_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  flags_t            q,
    input  logic              rd,
    output logic [BYTE_W-1:0] bus_out,
    output logic              oe
);
    // Gates the assembled byte onto the output.
    always_comb begin
        oe      = rd;
        bus_out = rd ? to_byte(q) : '0;
    end

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> bus_out == '0);
    p_bit3_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out[POS_NA] == 1'b0);

endmodule

// File: rtl/status_flags.sv
// Top level: status flag register with ALU-driven updates and bus load/read.
// Assumes: the carry flag's next value comes from a separate carry block.
module status_flags
    import status_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] alu_res,
    input  logic              alu_zero,
    input  logic              alu_half_cy,
    input  logic              alu_cy6,
    input  logic              alu_cy7,
    input  logic              arith_we,
    input  logic              chain_zero,
    input  logic              k_we,
    input  logic              v_we,
    input  logic              cy_we,
    input  logic              cy_next,
    input  logic              bus_load,
    input  logic [BYTE_W-1:0] bus_in,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe
);
    logic   c_sign, c_par, c_ovf, c_less;
    flags_t q;
    flags_t load_val;

    // Unpacks the bus byte for a load.
    always_comb load_val = from_byte(bus_in);

    flag_calc #(.DW(BYTE_W)) u_calc (
        .res        (alu_res),
        .cy_in_top  (alu_cy6),
        .cy_out_top (alu_cy7),
        .sign       (c_sign),
        .parity_even(c_par),
        .ovf        (c_ovf),
        .less       (c_less)
    );

    flag_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .arith_we  (arith_we),
        .chain_zero(chain_zero),
        .k_we      (k_we),
        .v_we      (v_we),
        .cy_we     (cy_we),
        .load      (bus_load),
        .load_val  (load_val),
        .n_sign    (c_sign),
        .n_zero    (alu_zero),
        .n_ac      (alu_half_cy),
        .n_par     (c_par),
        .n_k       (c_less),
        .n_v       (c_ovf),
        .n_c       (cy_next),
        .q         (q)
    );

    flag_bus u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .q      (q),
        .rd     (bus_rd),
        .bus_out(bus_out),
        .oe     (bus_oe)
    );

    p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_load && arith_we) |=> bus_rd |-> bus_out[POS_S] == $past(alu_res[BYTE_W-1]));
    p_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_load && v_we) |=> bus_rd |-> bus_out[POS_V] == ($past(alu_cy6) ^ $past(alu_cy7)));

endmodule

// File: tb/status_flags_test.sv
module status_flags_test;
    logic       clk = 0;
    logic       rst_n;
    logic [7:0] alu_res;
    logic       alu_zero, alu_half_cy, alu_cy6, alu_cy7;
    logic       arith_we, chain_zero, k_we, v_we, cy_we, cy_next;
    logic       bus_load, bus_rd;
    logic [7:0] bus_in;
    logic [7:0] bus_out;
    logic       bus_oe;

    int n_tests = 0;
    int n_fail  = 0;
    // model flags: s z k ac p v c
    logic m_s, m_z, m_k, m_ac, m_p, m_v, m_c;

    always #10 clk = ~clk;

    status_flags uut (
        .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_zero(alu_zero),
        .alu_half_cy(alu_half_cy), .alu_cy6(alu_cy6), .alu_cy7(alu_cy7),
        .arith_we(arith_we), .chain_zero(chain_zero), .k_we(k_we), .v_we(v_we),
        .cy_we(cy_we), .cy_next(cy_next), .bus_load(bus_load), .bus_in(bus_in),
        .bus_rd(bus_rd), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    function automatic logic [7:0] model_byte();
        return {m_s, m_z, m_k, m_ac, 1'b0, m_p, m_v, m_c};
    endfunction

    function automatic logic even_par(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return (n % 2) == 0;
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        arith_we = 0; chain_zero = 0; k_we = 0; v_we = 0; cy_we = 0;
        bus_load = 0; bus_rd = 0;
    endtask

    // Model update from the inputs present at the edge.
    task automatic model_edge();
        logic ovf;
        ovf = alu_cy6 ^ alu_cy7;
        if (bus_load) begin
            {m_s, m_z, m_k, m_ac} = bus_in[7:4];
            {m_p, m_v, m_c} = bus_in[2:0];
        end else begin
            if (arith_we) begin
                m_s  = alu_res[7];
                m_z  = chain_zero ? (m_z & alu_zero) : alu_zero;
                m_ac = alu_half_cy;
                m_p  = even_par(alu_res);
            end
            if (k_we) m_k = alu_res[7] ^ ovf;
            if (v_we) m_v = ovf;
            if (cy_we) m_c = cy_next;
        end
    endtask

    // One update cycle (read off, checked quiet), then one read cycle with enables off.
    task automatic step(string req);
        #1;
        check("R10 quiet", {bus_oe, bus_out}, 9'h000);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
        bus_rd = 1;
        #1;
        check(req, {bus_oe, bus_out}, {1'b1, model_byte()});
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic set_alu(logic [7:0] r, logic hc, logic c6, logic c7);
        alu_res = r; alu_zero = (r == 0); alu_half_cy = hc; alu_cy6 = c6; alu_cy7 = c7;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        set_alu(8'h00, 0, 0, 0);
        cy_next = 0; bus_in = 8'h00;
        rst_n = 0;
        {m_s, m_z, m_k, m_ac, m_p, m_v, m_c} = '0;
        // dirty the state before reset
        @(negedge clk); bus_load = 1; bus_in = 8'hFF;
        @(negedge clk); bus_load = 0;
        @(negedge clk); rst_n = 1; bus_rd = 1; #1;
        check("R1 reset", {bus_oe, bus_out}, 9'h100);
        @(negedge clk); bus_rd = 0;

        // R2: odd parity, sign set
        set_alu(8'h80, 1, 0, 0); arith_we = 1; step("R2 sign/ac/odd parity");
        // R2: zero result, even parity
        set_alu(8'h00, 0, 0, 0); arith_we = 1; step("R2 zero/even parity");
        set_alu(8'h3C, 0, 0, 0); arith_we = 1; step("R2 even parity nonzero");
        // R3: chained zero, low byte zero then high nonzero
        set_alu(8'h00, 0, 0, 0); arith_we = 1; step("R2 zero low byte");
        set_alu(8'h01, 0, 0, 0); arith_we = 1; chain_zero = 1; step("R3 chain nonzero high");
        set_alu(8'h00, 0, 0, 0); arith_we = 1; step("R2 zero again");
        set_alu(8'h00, 0, 0, 0); arith_we = 1; chain_zero = 1; step("R3 chain both zero");
        // R4: chain without arith enable leaves flags
        set_alu(8'h7F, 1, 0, 0); chain_zero = 1; step("R4 chain idle");
        // R5/R6: overflow 01 and 10, sign combos
        set_alu(8'h80, 0, 1, 0); v_we = 1; k_we = 1; step("R5 R6 ovf pos+pos");
        set_alu(8'h7F, 0, 0, 1); v_we = 1; k_we = 1; step("R5 R6 ovf neg+neg");
        set_alu(8'h90, 0, 1, 1); k_we = 1; step("R6 negative no ovf");
        // R7
        cy_next = 1; cy_we = 1; step("R7 carry set");
        cy_next = 0; cy_we = 1; step("R7 carry clear");
        // R8: only V enabled, lots of other activity on ALU
        set_alu(8'hFF, 1, 1, 0); cy_next = 1; v_we = 1; step("R8 only V");
        // R9: load with bit 3 set, with every other enable asserted
        bus_in = 8'hA5 | 8'h08; set_alu(8'h00, 1, 1, 0); cy_next = 0;
        bus_load = 1; arith_we = 1; chain_zero = 1; k_we = 1; v_we = 1; cy_we = 1;
        step("R9 load priority bit3 ignored");
        bus_in = 8'h5A; bus_load = 1; step("R9 load pattern");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (($urandom % 4) == 0) r = 8'h00;
            set_alu(r, 1'($urandom), 1'($urandom), 1'($urandom));
            arith_we   = ($urandom % 3) == 0;
            chain_zero = ($urandom % 3) == 0;
            k_we       = ($urandom % 3) == 0;
            v_we       = ($urandom % 3) == 0;
            cy_we      = ($urandom % 3) == 0;
            cy_next    = 1'($urandom);
            bus_load   = ($urandom % 8) == 0;
            bus_in     = 8'($urandom);
            if (bus_load) step("R9 random");
            else if (arith_we && chain_zero) step("R3 random");
            else if (chain_zero) step("R4 random");
            else if (arith_we) step("R2 random");
            else step("R8 random (R5 R6 R7)");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule